// File: doc/BRIEF.md
# BCD Calendar Timekeeping Core

This block holds wall-clock time and date as packed BCD bytes: seconds, minutes, hours, day of month, weekday, month and a two-digit year standing for 2000 to 2099. An external single-cycle enable, asserted once per second, advances the count. The carry runs from seconds up to the year. Month lengths and leap years are handled.

Software reaches the block through a byte-wide register port with an address, a write strobe, a read strobe and read data. A control byte at address 0x00 starts and stops the count, selects a 12-hour or 24-hour view of the hours byte, and triggers a software reset. Bit 7 of the seconds byte is a sticky flag meaning "time not trustworthy". Reset sets it. Software clears it when it loads the seconds byte with that bit at 0.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset, reads return 0x00 at 0x00, 0x80 at 0x03 (seconds 00 with the integrity flag set), 0x00 at 0x04, 0x05 and 0x07, and 0x01 at 0x06 (date) and 0x08 (month), 0x00 at 0x09 (year).
- R2: The integrity flag (seconds bit 7) is set by reset and by software reset. A write to 0x03 loads it from data bit 7. Otherwise it holds its value, and ticks do not change it.
- R3: On a tick while running, seconds (0x03, bits 6:0) and minutes (0x04) each step in BCD and roll 59 to 00, carrying into the next field.
- R4: The hours byte (0x05) rolls 23 to 00 and carries into the date (0x06). The weekday (0x07, 0 to 6) advances once per day and wraps 6 to 0.
- R5: While control bit 5 is 1, ticks leave every time field unchanged.
- R6: While control bit 3 is 1, the hours byte reads and writes in 12-hour form: bit 5 = PM, bits 4:0 = BCD 01 to 12. Midnight reads 0x12 and noon reads 0x32. The count passes from 11 PM to 12 AM. When the bit is 0, the byte is BCD 00 to 23.
- R7: The date rolls to 01 and carries into the month after 30 in months 04, 06, 09 and 11, and after 31 in the other months.
- R8: In February the date rolls after 29 when the year value is divisible by 4, and after 28 otherwise.
- R9: The month (0x08) rolls 12 to 01 and carries into the year (0x09). The year rolls 99 to 00.
- R10: Writing the control byte with bit 4 at 1 returns every time field to its reset value and sets the integrity flag. Bit 4 always reads 0.
- R11: Read data appears on the cycle after the read strobe. Addresses 0x01, 0x02 and all addresses above 0x09 read 0x00.
- R12: A write to any time field in the same cycle as a tick takes effect, and that tick is dropped for all fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |

## Verification
On every cycle, the assertions check the following: the count holds while stopped; the integrity flag stays set unless software writes it; a field write beats a coincident tick; a software reset returns the count to its initial value; and seconds and month wrap at their limits. The calendar behaviour needs the bench's scenarios. These cover 30-day and 31-day months, February in leap and non-leap years, and the century rollover. The bench also covers the 12-hour translation in both directions and the one-cycle read latency.

// File: rtl/bcd_rtc_pkg.sv
// Shared types and BCD helper functions for the calendar timekeeping core.
// Assumes packed BCD values below 100 and years meaning 2000..2099.
package bcd_rtc_pkg;

    localparam int FIELDS   = 7;
    localparam int REG_CTRL = 0;
    localparam int REG_SEC  = 3;
    localparam int REG_MIN  = 4;
    localparam int REG_HR   = 5;
    localparam int REG_DATE = 6;
    localparam int REG_WDAY = 7;
    localparam int REG_MON  = 8;
    localparam int REG_YR   = 9;

    localparam int CTRL_H12  = 3;
    localparam int CTRL_SRST = 4;
    localparam int CTRL_STOP = 5;

    typedef struct packed {
        logic [7:0] sec;   // bit 7 = integrity flag
        logic [7:0] min;
        logic [7:0] hr;    // always 24-hour BCD internally
        logic [7:0] date;
        logic [7:0] wday;
        logic [7:0] mon;
        logic [7:0] yr;
    } rtc_time_t;

    localparam rtc_time_t TIME_INIT = '{sec: 8'h80, min: 8'h00, hr: 8'h00,
                                        date: 8'h01, wday: 8'h00,
                                        mon: 8'h01, yr: 8'h00};

    function automatic logic [6:0] bcd2bin(input logic [7:0] b);
        return {3'b0, b[7:4]} * 7'd10 + {3'b0, b[3:0]};
    endfunction

    function automatic logic [7:0] bin2bcd(input logic [6:0] v);
        logic [6:0] t;
        logic [6:0] u;
        t = v / 7'd10;
        u = v - t * 7'd10;
        return {t[3:0], u[3:0]};
    endfunction

    // {wrap, next}: steps v by one in BCD, wrapping to 00 past lim.
    function automatic logic [8:0] bcd_step(input logic [7:0] v, input logic [7:0] lim);
        if (v >= lim)
            return 9'h100;
        else if (v[3:0] >= 4'd9)
            return {1'b0, v[7:4] + 4'd1, 4'd0};
        else
            return {1'b0, v[7:4], v[3:0] + 4'd1};
    endfunction

    // Year value divisible by four: 10*tens + units = 2*tens + units (mod 4).
    function automatic logic is_leap(input logic [7:0] yr);
        logic [1:0] r;
        r = {yr[4], 1'b0} + yr[1:0];
        return (r == 2'd0);
    endfunction

    function automatic logic [7:0] last_day(input logic [7:0] mon, input logic [7:0] yr);
        case (mon)
            8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    // 24-hour BCD (0..23) to 12-hour byte: bit 5 PM, bits 4:0 BCD 1..12.
    function automatic logic [7:0] hr_to_12(input logic [5:0] h24);
        logic [6:0] b;
        logic [6:0] h;
        logic [7:0] d;
        b = bcd2bin({2'b0, h24});
        if (b == 7'd0)       h = 7'd12;
        else if (b > 7'd12)  h = b - 7'd12;
        else                 h = b;
        d = bin2bcd(h);
        return {2'b0, (b >= 7'd12), d[4:0]};
    endfunction

    // 12-hour byte (bit 5 PM, bits 4:0 BCD) to 24-hour BCD.
    function automatic logic [5:0] hr_from_12(input logic [5:0] v);
        logic [6:0] b;
        logic [7:0] d;
        b = bcd2bin({3'b0, v[4:0]});
        if (b == 7'd12) b = 7'd0;
        if (v[5])       b = b + 7'd12;
        d = bin2bcd(b);
        return d[5:0];
    endfunction

endpackage

// File: rtl/bcd_rtc_timebase.sv
// Time and calendar counter chain. Holds all seven BCD fields, loads a
// single field on request, and advances the whole chain by one second when
// told to. Assumes the caller never asserts advance and a load together.
module bcd_rtc_timebase
    import bcd_rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    input  logic [FIELDS-1:0] ld_en,
    input  logic [7:0]        ld_data,
    output rtc_time_t         now
);

    rtc_time_t  nxt;
    logic [8:0] s_st, m_st, h_st, d_st, mo_st, y_st;
    logic       c_min, c_hr, c_day, c_mon, c_yr;

    // Next-second value of every field with the carry chain.
    always_comb begin
        s_st  = bcd_step({1'b0, now.sec[6:0]}, 8'h59);
        m_st  = bcd_step(now.min, 8'h59);
        h_st  = bcd_step(now.hr, 8'h23);
        d_st  = bcd_step(now.date, last_day(now.mon, now.yr));
        mo_st = bcd_step(now.mon, 8'h12);
        y_st  = bcd_step(now.yr, 8'h99);

        c_min = s_st[8];
        c_hr  = c_min & m_st[8];
        c_day = c_hr & h_st[8];
        c_mon = c_day & d_st[8];
        c_yr  = c_mon & mo_st[8];

        nxt      = now;
        nxt.sec  = {now.sec[7], s_st[6:0]};
        if (c_min) nxt.min  = m_st[7:0];
        if (c_hr)  nxt.hr   = h_st[7:0];
        if (c_day) nxt.date = d_st[8] ? 8'h01 : d_st[7:0];
        if (c_day) nxt.wday = (now.wday >= 8'h06) ? 8'h00 : now.wday + 8'h01;
        if (c_mon) nxt.mon  = mo_st[8] ? 8'h01 : mo_st[7:0];
        if (c_yr)  nxt.yr   = y_st[7:0];
    end

    // Field storage: reset, field load or one-second advance.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            now <= TIME_INIT;
        end else if (|ld_en) begin
            if (ld_en[0]) now.sec  <= ld_data;
            if (ld_en[1]) now.min  <= ld_data;
            if (ld_en[2]) now.hr   <= ld_data;
            if (ld_en[3]) now.date <= ld_data;
            if (ld_en[4]) now.wday <= ld_data;
            if (ld_en[5]) now.mon  <= ld_data;
            if (ld_en[6]) now.yr   <= ld_data;
        end else if (advance) begin
            now <= nxt;
        end
    end

endmodule

// File: rtl/bcd_rtc_regs.sv
// Register port: control byte, write decode with field masking and
// 12-hour translation, and registered read-back. Assumes at most one
// register access per cycle.
module bcd_rtc_regs
    import bcd_rtc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        wdata,
    input  rtc_time_t         now,
    output logic [7:0]        rdata,
    output logic [FIELDS-1:0] ld_en,
    output logic [7:0]        ld_data,
    output logic              clear,
    output logic              run
);

    logic       stop_q;
    logic       h12_q;
    logic       ctrl_wr;
    logic [7:0] rd_mux;

    assign ctrl_wr = wr_en && (addr == ADDR_W'(REG_CTRL));
    assign clear   = ctrl_wr && wdata[CTRL_SRST];
    assign run     = !stop_q;

    // Write decode: one-hot field select and masked field value.
    always_comb begin
        for (int i = 0; i < FIELDS; i++)
            ld_en[i] = wr_en && (addr == ADDR_W'(REG_SEC + i));
        case (addr)
            ADDR_W'(REG_MIN):  ld_data = {1'b0, wdata[6:0]};
            ADDR_W'(REG_HR):   ld_data = {2'b0, h12_q ? hr_from_12(wdata[5:0]) : wdata[5:0]};
            ADDR_W'(REG_DATE): ld_data = {2'b0, wdata[5:0]};
            ADDR_W'(REG_WDAY): ld_data = {5'b0, wdata[2:0]};
            ADDR_W'(REG_MON):  ld_data = {3'b0, wdata[4:0]};
            default:           ld_data = wdata;
        endcase
    end

    // Control byte storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_q <= 1'b0;
            h12_q  <= 1'b0;
        end else if (ctrl_wr) begin
            stop_q <= wdata[CTRL_STOP];
            h12_q  <= wdata[CTRL_H12];
        end
    end

    // Read-back selection.
    always_comb begin
        case (addr)
            ADDR_W'(REG_CTRL): rd_mux = {2'b0, stop_q, 1'b0, h12_q, 3'b0};
            ADDR_W'(REG_SEC):  rd_mux = now.sec;
            ADDR_W'(REG_MIN):  rd_mux = now.min;
            ADDR_W'(REG_HR):   rd_mux = h12_q ? hr_to_12(now.hr[5:0]) : now.hr;
            ADDR_W'(REG_DATE): rd_mux = now.date;
            ADDR_W'(REG_WDAY): rd_mux = now.wday;
            ADDR_W'(REG_MON):  rd_mux = now.mon;
            ADDR_W'(REG_YR):   rd_mux = now.yr;
            default:           rd_mux = 8'h00;
        endcase
    end

    // Registered read data, updated on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= 8'h00;
        else if (rd_en)
            rdata <= rd_mux;
    end

endmodule

// File: rtl/bcd_rtc_core.sv
// Top of the BCD calendar timekeeping core. Joins the register port to the
// counter chain and gates the one-second enable with run and field writes.
// Assumes tick_1hz is a single-cycle pulse synchronous to clk.
module bcd_rtc_core
    import bcd_rtc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);

    rtc_time_t         now;
    logic [FIELDS-1:0] ld_en;
    logic [7:0]        ld_data;
    logic              clear;
    logic              run;
    logic              advance;

    // A field write in the same cycle drops the tick.
    assign advance = tick_1hz && run && !(|ld_en);

    bcd_rtc_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .wdata   (wdata),
        .now     (now),
        .rdata   (rdata),
        .ld_en   (ld_en),
        .ld_data (ld_data),
        .clear   (clear),
        .run     (run)
    );

    bcd_rtc_timebase u_time (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .advance (advance),
        .ld_en   (ld_en),
        .ld_data (ld_data),
        .now     (now)
    );

endmodule

// File: rtl/bcd_rtc_checker.sv
// Cycle-by-cycle properties of the timekeeping core, bound to its top.
module bcd_rtc_checker #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_1hz,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        wdata,
    input logic              run,
    input logic [7:0]        sec_q,
    input logic [7:0]        min_q,
    input logic [7:0]        hr_q,
    input logic [7:0]        date_q,
    input logic [7:0]        mon_q,
    input logic [7:0]        yr_q
);

    logic sec_wr;
    logic ctl_wr;
    assign sec_wr = wr_en && (addr == ADDR_W'(3));
    assign ctl_wr = wr_en && (addr == ADDR_W'(0));

    // R5: a stopped count holds every field.
    p_stop_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_en) |=> ($stable(sec_q) && $stable(min_q) && $stable(hr_q)
                              && $stable(date_q) && $stable(mon_q) && $stable(yr_q)));

    // R2: the integrity flag stays set until software writes seconds.
    p_flag_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_q[7] && !sec_wr) |=> sec_q[7]);

    // R3: seconds wrap from 59 to 00 on a tick.
    p_sec_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick_1hz && !wr_en && sec_q[6:0] == 7'h59) |=> (sec_q[6:0] == 7'h00));

    // R9: end of December rolls month to January.
    p_mon_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick_1hz && !wr_en && sec_q[6:0] == 7'h59 && min_q == 8'h59
         && hr_q == 8'h23 && date_q == 8'h31 && mon_q == 8'h12) |=> (mon_q == 8'h01));

    // R10: software reset restores the initial time and sets the flag.
    p_soft_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wdata[4]) |=> (sec_q == 8'h80 && min_q == 8'h00 && hr_q == 8'h00
                                  && date_q == 8'h01 && mon_q == 8'h01 && yr_q == 8'h00));

    // R12: a seconds write beats a same-cycle tick, which is dropped.
    p_write_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_wr && tick_1hz && run) |=> (sec_q == $past(wdata) && $stable(min_q)));

endmodule

bind bcd_rtc_core bcd_rtc_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_1hz (tick_1hz),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .run      (run),
    .sec_q    (now.sec),
    .min_q    (now.min),
    .hr_q     (now.hr),
    .date_q   (now.date),
    .mon_q    (now.mon),
    .yr_q     (now.yr)
);

// File: tb/bcd_rtc_core_bench.sv
// Self-checking bench: a vector table of one-tick calendar steps, then
// directed tests for reset, flag, stop, 12-hour mode and access corners.
module bcd_rtc_core_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 11;

    // Each entry: {sec,min,hr,date,wday,mon,yr} before and after one tick.
    localparam logic [55:0] VEC_IN [NV] = '{
        56'h00_00_00_01_00_01_00, 56'h59_00_00_01_00_01_00,
        56'h59_59_10_15_02_06_24, 56'h59_59_23_15_06_06_24,
        56'h59_59_23_30_03_04_23, 56'h59_59_23_30_03_05_23,
        56'h59_59_23_28_01_02_24, 56'h59_59_23_29_01_02_24,
        56'h59_59_23_28_01_02_23, 56'h59_59_23_31_05_12_99,
        56'h59_59_23_31_05_12_23};
    localparam logic [55:0] VEC_OUT [NV] = '{
        56'h01_00_00_01_00_01_00, 56'h00_01_00_01_00_01_00,
        56'h00_00_11_15_02_06_24, 56'h00_00_00_16_00_06_24,
        56'h00_00_00_01_04_05_23, 56'h00_00_00_31_04_05_23,
        56'h00_00_00_29_02_02_24, 56'h00_00_00_01_02_03_24,
        56'h00_00_00_01_02_03_23, 56'h00_00_00_01_06_01_00,
        56'h00_00_00_01_06_01_24};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic [7:0] addr = 8'h00;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;

    int checks = 0;
    int fails  = 0;

    bcd_rtc_core u_bcd_rtc_core (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .addr(addr),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic string vec_tag(input int i);
        case (i)
            0, 1, 2: return "R3";
            3:       return "R4";
            4, 5:    return "R7";
            6, 7, 8: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input logic [55:0] got, input logic [55:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic tick();
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
    endtask

    task automatic load_all(input logic [55:0] v);
        for (int k = 0; k < 7; k++)
            wr(8'(3 + k), v[55 - 8*k -: 8]);
    endtask

    task automatic read_all(output logic [55:0] v);
        logic [7:0] b;
        for (int k = 0; k < 7; k++) begin
            rd(8'(3 + k), b);
            v[55 - 8*k -: 8] = b;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0]  b;
        logic [55:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values of control and all fields.
        rd(8'h00, b); check("R1 ctrl", {48'h0, b}, {48'h0, 8'h00});
        read_all(v);  check("R1 fields", v, 56'h80_00_00_01_00_01_00);

        // R11: reserved addresses read zero; one-cycle read latency.
        rd(8'h01, b); check("R11 addr01", {48'h0, b}, 56'h0);
        rd(8'h0A, b); check("R11 addr0A", {48'h0, b}, 56'h0);

        // R2: flag survives ticks, then is written from bit 7.
        tick(); rd(8'h03, b); check("R2 sticky", {48'h0, b}, {48'h0, 8'h81});
        wr(8'h03, 8'h00); tick(); rd(8'h03, b); check("R2 clear", {48'h0, b}, {48'h0, 8'h01});

        // Table walk: each vector loaded, ticked once, read back.
        for (int i = 0; i < NV; i++) begin
            wr(8'h00, 8'h00);
            load_all(VEC_IN[i]);
            tick();
            read_all(v);
            check(vec_tag(i), v, VEC_OUT[i]);
        end

        // R5: stopped count ignores ticks.
        load_all(56'h45_30_12_10_03_07_25);
        wr(8'h00, 8'h20);
        repeat (3) tick();
        read_all(v); check("R5 stop", v, 56'h45_30_12_10_03_07_25);

        // R6: 12-hour view of 23, 00 and 12 hours, and 12-hour writes.
        wr(8'h00, 8'h00); wr(8'h05, 8'h23); wr(8'h00, 8'h08);
        rd(8'h05, b); check("R6 11pm", {48'h0, b}, {48'h0, 8'h31});
        wr(8'h00, 8'h00); wr(8'h05, 8'h00); wr(8'h00, 8'h08);
        rd(8'h05, b); check("R6 midnight", {48'h0, b}, {48'h0, 8'h12});
        wr(8'h05, 8'h32); wr(8'h00, 8'h00);
        rd(8'h05, b); check("R6 noon write", {48'h0, b}, {48'h0, 8'h12});
        wr(8'h00, 8'h08); wr(8'h05, 8'h12); wr(8'h00, 8'h00);
        rd(8'h05, b); check("R6 12am write", {48'h0, b}, {48'h0, 8'h00});
        wr(8'h00, 8'h08); wr(8'h05, 8'h31); wr(8'h04, 8'h59); wr(8'h03, 8'h59);
        tick(); rd(8'h05, b); check("R6 pm wrap", {48'h0, b}, {48'h0, 8'h12});

        // R12: field write and tick in one cycle; write wins, tick dropped.
        wr(8'h00, 8'h00); wr(8'h04, 8'h10); wr(8'h03, 8'h59);
        @(negedge clk);
        addr = 8'h03; wdata = 8'h42; wr_en = 1'b1; tick_1hz = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick_1hz = 1'b0;
        rd(8'h03, b); check("R12 sec", {48'h0, b}, {48'h0, 8'h42});
        rd(8'h04, b); check("R12 min", {48'h0, b}, {48'h0, 8'h10});

        // R10: software reset restores the initial time; bit 4 reads zero.
        load_all(56'h12_34_15_20_02_09_31);
        wr(8'h00, 8'h18);
        rd(8'h00, b); check("R10 ctrl", {48'h0, b}, {48'h0, 8'h08});
        wr(8'h00, 8'h00);
        read_all(v); check("R10 fields", v, 56'h80_00_00_01_00_01_00);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule